// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver

This block is a write-only slave for a two-wire open-drain serial bus. It runs on a fast system clock and oversamples the clock line and the data line. It recognises the bus conditions that open and close a transfer. It collects an address and a direction bit, then compares the address with a programmable own address. The all-zero address can also be accepted as a broadcast (general call). The block acknowledges an accepted address and the data bytes that follow it. Each byte it receives appears on a parallel output together with a one-cycle strobe.

The block never drives a line high. Its two outputs are pull-down enables, and the surrounding pad logic turns them into open-drain drivers. A user-side busy input has two effects. During an address it makes the block refuse service. During the acknowledge slot of a data byte it holds the clock line low until the user is ready. A separate refuse input lets the user decline any further bytes.

Top module: `tws_slave_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sda_oe`, `scl_oe` and `rx_valid` are all 0.
- R2: A falling data line while the clock line is high (START) restarts address reception from any state, including in the middle of a transfer. A rising data line while the clock line is high (STOP) returns the block to idle, and a byte that follows with no START is ignored and not acknowledged.
- R3: The address byte is seven address bits, most significant bit first, followed by a direction bit in which 1 means read. When the address equals `own_addr`, the direction bit is 0 and `busy` is low, the block acknowledges by asserting `sda_oe` through the ninth clock pulse.
- R4: A non-matching address is not acknowledged, and everything up to the next START is ignored: no acknowledge and no `rx_valid`.
- R5: Address 0000000 with the direction bit 0 is acknowledged only when `gc_en` is 1, and every byte received in that transfer has `rx_gc` = 1. Address 0 is never compared against `own_addr`.
- R6: An address byte whose direction bit is 1 is never acknowledged. This holds for the general call address even when `gc_en` is 1.
- R7: If `busy` is high when the direction bit is sampled, the address is not acknowledged.
- R8: Data bytes are eight bits, most significant bit first. After the eighth bit, `rx_data` holds the byte and `rx_valid` pulses for exactly one cycle. The byte is acknowledged unless `nack_req` is high.
- R9: If `nack_req` is high when the eighth data bit is sampled, the byte is still presented but is not acknowledged, and later bytes are ignored until the next START.
- R10: During the acknowledge slot of a data byte, `scl_oe` holds the clock line low for as long as `busy` is high, and is released once `busy` falls. `scl_oe` is never asserted while the clock line is high.
- R11: `sda_oe` changes only while the clock line is low. It goes high after the falling edge that ends the last bit of a byte and goes low at the falling edge that ends the acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| own_addr | input | 7 | Programmed slave address |
| gc_en | input | 1 | Accept the general call address |
| busy | input | 1 | User not ready: refuse the address, stretch the data acknowledge |
| nack_req | input | 1 | Refuse the current data byte and all later ones |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is updated |
| rx_gc | output | 1 | Byte belongs to a general call transfer |

## Verification
The assertions assume that the bus master obeys the line protocol. Data only moves while the clock line is low, except at START and STOP. Each clock phase also lasts well beyond the synchronizer delay, so a drive change made after a detected falling edge still falls inside the low phase. The bench master keeps every phase at ten system clocks or more and changes data three clocks into the low phase. It waits for the wired-AND clock line to go high before it times its own high phase, which is how it tolerates stretching. It never issues a STOP while the slave is holding the data line low.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TWS_DATA_W = 8;
    localparam int TWS_ADDR_W = TWS_DATA_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_ACK_HIGH,
        ST_DATA
    } tws_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tws_evt_t;

    // Address acceptance rule: address zero is the broadcast and is only
    // taken as a write with broadcasts enabled; reads are never served.
    function automatic logic tws_addr_accept(
        input logic [TWS_ADDR_W-1:0] addr,
        input logic [TWS_ADDR_W-1:0] own,
        input logic                  rw,
        input logic                  gc_en,
        input logic                  busy
    );
        logic hit;
        hit = (addr == '0) ? gc_en : (addr == own);
        return hit && !rw && !busy;
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[STAGES-2:0], din[b]};
        end
        assign dout[b] = q[STAGES-1];
    end
endmodule

// File: rtl/tws_cond.sv
module tws_cond
    import tws_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output tws_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter int DATA_W = TWS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  tws_evt_t          evt,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              gc_en,
    input  logic              busy,
    input  logic              nack_req,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_gc,
    output tws_state_e        state
);
    localparam int SH_W  = DATA_W - 1;
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    tws_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic             gc_q;

    assign state = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            gc_q     <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_gc    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            scl_oe   <= (st == ST_ACK_HOLD) && busy && !evt.scl_rise;
            if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: if (evt.scl_rise) begin
                        sh  <= {sh[SH_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            gc_q <= (sh == '0);
                            st   <= tws_addr_accept(sh, own_addr, sda_s, gc_en, busy)
                                    ? ST_ACK_SETUP : ST_IDLE;
                        end
                    end
                    ST_ACK_SETUP: if (evt.scl_fall) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (evt.scl_rise) st <= ST_ACK_HIGH;
                    ST_ACK_HIGH: if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_DATA;
                    end
                    ST_DATA: if (evt.scl_rise) begin
                        sh  <= {sh[SH_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            rx_data  <= {sh, sda_s};
                            rx_valid <= 1'b1;
                            rx_gc    <= gc_q;
                            st       <= nack_req ? ST_IDLE : ST_ACK_SETUP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tws_slave_rx.sv
module tws_slave_rx
    import tws_pkg::*;
#(
    parameter int DATA_W      = TWS_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              gc_en,
    input  logic              busy,
    input  logic              nack_req,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_gc
);
    logic       scl_s, sda_s;
    tws_evt_t   evt;
    tws_state_e st;

    tws_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    tws_cond cond_i (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    tws_engine #(.DATA_W(DATA_W)) eng_i (
        .clk      (clk),
        .rst      (rst),
        .sda_s    (sda_s),
        .evt      (evt),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .busy     (busy),
        .nack_req (nack_req),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_gc    (rx_gc),
        .state    (st)
    );
endmodule

// File: rtl/tws_slave_rx_chk.sv
module tws_slave_rx_chk
    import tws_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       rx_valid,
    input tws_state_e st
);
    // R11: the data-line drive moves only inside a low clock phase
    a_r11_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R10: stretching only ever extends a low phase
    a_r10_stretch_low_only: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> !scl_s);

    // R8: strobe lasts a single cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R11: data line already released when a byte completes
    a_r11_released_at_byte: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !sda_oe);

    // R4: an idle slave does not drive the data line
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);
endmodule

bind tws_slave_rx tws_slave_rx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .rx_valid (rx_valid),
    .st       (st)
);

// File: tb/tws_slave_rx_tb.sv
module tws_slave_rx_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_oe, sda_oe, rx_valid, rx_gc;
    logic [7:0] rx_data;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_en = 1'b0, busy_lvl = 1'b0, nack_req = 1'b0;
    logic       busy;
    wire        scl_bus = scl_m & ~scl_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    int cyc = 0, busy_until = 0;
    int checks = 0, errors = 0;
    int sda_viol = 0;
    bit done = 0;
    logic [8:0] exp_q[$];
    logic ref_on = 1'b0, ref_gc = 1'b0;
    int last_wait;

    assign busy = busy_lvl || (cyc < busy_until);

    tws_slave_rx dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .own_addr(own_addr), .gc_en(gc_en), .busy(busy), .nack_req(nack_req),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_gc(rx_gc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // per-cycle reference comparison
    logic prev_sda_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                if (exp_q.size() == 0)
                    chk(0, "R4", "unexpected byte", int'(rx_data), -1);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e[7:0], "R8", "rx_data", int'(rx_data), int'(e[7:0]));
                    chk(rx_gc == e[8], "R5", "rx_gc", int'(rx_gc), int'(e[8]));
                end
            end
            if (sda_oe != prev_sda_oe && scl_bus) sda_viol++;
            if (scl_oe && scl_m && scl_bus) sda_viol++;
        end
        prev_sda_oe <= sda_oe;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high(output int n);
        n = 0;
        while (!scl_bus) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic m_start();
        int n;
        wclk(5); sda_m = 1'b1; scl_m = 1'b1;
        wait_high(n); wclk(10);
        sda_m = 1'b0; wclk(10);
        scl_m = 1'b0; wclk(5);
    endtask

    task automatic m_stop();
        int n;
        wclk(3); sda_m = 1'b0; wclk(7);
        scl_m = 1'b1; wait_high(n); wclk(10);
        sda_m = 1'b1; wclk(10);
    endtask

    task automatic m_byte(input logic [7:0] b, input int stretch,
                          output logic ack, output int w);
        int n;
        for (int i = 7; i >= 0; i--) begin
            wclk(3); sda_m = b[i]; wclk(7);
            scl_m = 1'b1; wait_high(n); wclk(10);
            scl_m = 1'b0;
        end
        if (stretch > 0) busy_until = cyc + stretch;
        wclk(3); sda_m = 1'b1; wclk(7);
        scl_m = 1'b1; wait_high(w); wclk(5);
        ack = !sda_bus; wclk(5);
        scl_m = 1'b0;
    endtask

    task automatic addr(input logic [6:0] a, input logic rw, input string tag);
        logic ak, e; int w;
        e = !busy_lvl && !rw && ((a == 7'd0) ? gc_en : (a == own_addr));
        m_byte({a, rw}, 0, ak, w);
        chk(ak == e, tag, "address ack", int'(ak), int'(e));
        ref_on = e;
        ref_gc = (a == 7'd0);
    endtask

    task automatic data(input logic [7:0] b, input int stretch, input string tag);
        logic ak, e;
        e = ref_on && !nack_req;
        if (ref_on) exp_q.push_back({ref_gc, b});
        m_byte(b, stretch, ak, last_wait);
        chk(ak == e, tag, "data ack", int'(ak), int'(e));
        if (nack_req) ref_on = 1'b0;
    endtask

    initial begin
        wclk(3);
        // R1: reset state
        chk(!sda_oe && !scl_oe && !rx_valid, "R1", "outputs in reset",
            int'({sda_oe, scl_oe, rx_valid}), 0);
        rst = 1'b0;
        wclk(1);
        chk(!sda_oe && !scl_oe && !rx_valid, "R1", "outputs after reset",
            int'({sda_oe, scl_oe, rx_valid}), 0);

        // R3 R8: plain write to own address
        m_start(); addr(7'h5A, 1'b0, "R3");
        data(8'hA5, 0, "R8"); data(8'h3C, 0, "R8"); m_stop();
        // R4: mismatch, following byte ignored
        m_start(); addr(7'h5B, 1'b0, "R4"); data(8'hFF, 0, "R4"); m_stop();
        // R5: general call enabled and disabled
        gc_en = 1'b1;
        m_start(); addr(7'h00, 1'b0, "R5"); data(8'h81, 0, "R5"); m_stop();
        gc_en = 1'b0;
        m_start(); addr(7'h00, 1'b0, "R5"); data(8'h18, 0, "R5"); m_stop();
        // R6: reads refused, including broadcast read
        gc_en = 1'b1;
        m_start(); addr(7'h00, 1'b1, "R6"); m_stop();
        m_start(); addr(7'h5A, 1'b1, "R6"); m_stop();
        gc_en = 1'b0;
        // R7: busy during address
        busy_lvl = 1'b1;
        m_start(); addr(7'h5A, 1'b0, "R7"); m_stop();
        busy_lvl = 1'b0;
        // R10: stretching during data acknowledge
        m_start(); addr(7'h5A, 1'b0, "R10");
        data(8'h77, 60, "R10");
        chk(last_wait >= 40, "R10", "stretched cycles", last_wait, 40);
        data(8'h12, 0, "R10");
        chk(last_wait <= 2, "R10", "unstretched cycles", last_wait, 0);
        m_stop();
        // R9: refusal by user
        m_start(); addr(7'h5A, 1'b0, "R9");
        nack_req = 1'b1; data(8'h99, 0, "R9");
        nack_req = 1'b0; data(8'h44, 0, "R9");
        m_stop();
        // R2: repeated start mid-transfer
        m_start(); addr(7'h5A, 1'b0, "R2"); data(8'h10, 0, "R2");
        m_start(); addr(7'h5B, 1'b0, "R2");
        m_start(); addr(7'h5A, 1'b0, "R2"); data(8'h20, 0, "R2");
        m_stop();
        // R2: after STOP, a matching address byte without START is ignored
        ref_on = 1'b0;
        wclk(5); scl_m = 1'b0; wclk(5);
        data(8'hB4, 0, "R2");
        m_stop();

        wclk(20);
        chk(exp_q.size() == 0, "R8", "bytes still expected", exp_q.size(), 0);
        chk(sda_viol == 0, "R11", "drive changes with clock high", sda_viol, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule